// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Trap

This block adds or subtracts two 32-bit operands that each carry a 2-bit type tag in their two least significant bits. A well-formed operand has both tag bits clear. When an operation is presented, the unit checks the tags and signed overflow in the same cycle. If either check fails, it raises a trap instead of reporting a flag. The sum or difference and the trap indication are combinational outputs. They are aligned with the valid strobe, so a pipeline stage can sample them in the same cycle it issues the operation.

Four condition-code bits (negative, zero, overflow, carry) sit in a register. They are loaded on the clock edge that ends a valid operation, but only when that operation did not trap. A trapping operation, or a cycle with no valid operation, leaves them untouched. Overflow always traps, so the stored overflow bit is always written as zero. The asynchronous active-low reset is released synchronously inside the block.

Top module: `tagged_arith_unit`

## Requirements
- R1: With `op_valid` high, if bit 0 or bit 1 of either operand is 1, `trap` is 1 in that same cycle, for both add and subtract.
- R2: With `op_valid` high and `op_sub` 0, `trap` is 1 whenever both operands have the same sign bit (bit 31) and the 32-bit sum has the other sign bit.
- R3: With `op_valid` high and `op_sub` 1, `trap` is 1 whenever the operands differ in bit 31 and the 32-bit difference has a sign bit different from the first operand.
- R4: `result` equals `opnd_a + opnd_b` modulo 2^32 when `op_sub` is 0, and `opnd_a - opnd_b` modulo 2^32 when `op_sub` is 1. It is checked only when `op_valid` is 1 and `trap` is 0.
- R5: `trap` is 0 in every cycle where `op_valid` is 0, whatever the operands are.
- R6: The condition codes keep their values across a clock edge where `op_valid` is 0 or `trap` is 1.
- R7: After an edge with a valid, non-trapping operation, `cc_n` equals bit 31 of that operation's result, and `cc_z` is 1 exactly when that result was zero.
- R8: After a valid non-trapping add, `cc_c` is 1 exactly when the unsigned sum is smaller than `opnd_a`, i.e. the add carried out of bit 31.
- R9: After a valid non-trapping subtract, `cc_c` is 1 exactly when `opnd_a` is unsigned-less-than `opnd_b`.
- R10: After a valid non-trapping operation, `cc_v` is 0.
- R11: While reset is asserted, and after it is released until the first update, all four condition-code bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sub | input | 1 | 1 selects subtract, 0 selects add |
| opnd_a | input | 32 | First operand; bits 1:0 are its tag |
| opnd_b | input | 32 | Second operand; bits 1:0 are its tag |
| result | output | 32 | Sum or difference; meaningful when trap is 0 |
| trap | output | 1 | Tag or overflow trap, same cycle as op_valid |
| cc_n | output | 1 | Registered negative flag |
| cc_z | output | 1 | Registered zero flag |
| cc_v | output | 1 | Registered overflow flag |
| cc_c | output | 1 | Registered carry/borrow flag |

## Verification
The bench sends operands with a tag bit set in only one of the two operands. A design that checks only the first operand, or only one tag bit, would let those operations through and update the flags. It adds and subtracts across the sign boundary in both directions: a wrong overflow formula either misses the trap or raises it on a legal carry such as a negative plus a positive. It checks the carry flag of a subtract against the borrow sense, which an inverted carry-out would get wrong. After each trap it checks that the flags were not touched, which catches an update enable that ignores the trap. Cycles with bad tags but no valid strobe must neither raise a trap nor change the flags.

// File: rtl/tagarith_pkg.sv
package tagarith_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  localparam cc_t CC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/tagarith_rst_sync.sv
module tagarith_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/tagarith_tag_chk.sv
module tagarith_tag_chk #(
  parameter int WIDTH = 32,
  parameter int TAG_W = 2
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             tag_bad
);

  logic [TAG_W-1:0] tag_or;

  generate
    for (genvar i = 0; i < TAG_W; i++) begin : g_tag
      assign tag_or[i] = opnd_a[i] | opnd_b[i];
    end
  endgenerate

  assign tag_bad = |tag_or;

endmodule

// File: rtl/tagarith_addsub.sv
module tagarith_addsub #(
  parameter int WIDTH = 32
) (
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_flag,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = op_sub ? ~opnd_b : opnd_b;
    wide  = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, op_sub};
    sum   = wide[WIDTH-1:0];
    // carry out for add, inverted carry (borrow) for subtract
    carry_flag = wide[WIDTH] ^ op_sub;
    // same-sign inputs to the adder giving a result of the other sign
    ovf = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
  end

endmodule

// File: rtl/tagarith_cc_reg.sv
module tagarith_cc_reg
  import tagarith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] sum,
  input  logic             carry_flag,
  output cc_t              cc
);

  cc_t cc_q;
  cc_t cc_d;

  always_comb begin
    cc_d = cc_q;
    if (upd_en) begin
      cc_d.n = sum[WIDTH-1];
      cc_d.z = (sum == '0);
      cc_d.v = 1'b0;
      cc_d.c = carry_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cc_q <= CC_CLEAR;
    else        cc_q <= cc_d;
  end

  assign cc = cc_q;

endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
  import tagarith_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int TAG_W     = 2,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             trap,
  output logic             cc_n,
  output logic             cc_z,
  output logic             cc_v,
  output logic             cc_c
);

  logic             rst_q;
  logic             tag_bad;
  logic [WIDTH-1:0] sum;
  logic             carry_flag;
  logic             ovf;
  logic             upd_en;
  cc_t              cc;

  tagarith_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  tagarith_tag_chk #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_tag (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .tag_bad (tag_bad)
  );

  tagarith_addsub #(.WIDTH(WIDTH)) u_alu (
    .op_sub     (op_sub),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sum        (sum),
    .carry_flag (carry_flag),
    .ovf        (ovf)
  );

  assign trap   = op_valid & (tag_bad | ovf);
  assign upd_en = op_valid & ~(tag_bad | ovf);
  assign result = sum;

  tagarith_cc_reg #(.WIDTH(WIDTH)) u_cc (
    .clk        (clk),
    .rst_q      (rst_q),
    .upd_en     (upd_en),
    .sum        (sum),
    .carry_flag (carry_flag),
    .cc         (cc)
  );

  assign cc_n = cc.n;
  assign cc_z = cc.z;
  assign cc_v = cc.v;
  assign cc_c = cc.c;

endmodule

// File: rtl/tagged_arith_chk.sv
module tagged_arith_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic             op_valid,
  input logic             op_sub,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             trap,
  input logic             cc_n,
  input logic             cc_z,
  input logic             cc_v,
  input logic             cc_c
);

  localparam int MSB = WIDTH - 1;

  // R1
  tag_trap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && (opnd_a[1:0] != 2'b00 || opnd_b[1:0] != 2'b00)) |-> trap);

  // R2
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !op_sub && opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]) |-> trap);

  // R3
  sub_ovf_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_sub && opnd_a[MSB] != opnd_b[MSB] && result[MSB] != opnd_a[MSB]) |-> trap);

  // R5
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !op_valid |-> !trap);

  // R6
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!op_valid || trap) |=> $stable({cc_n, cc_z, cc_v, cc_c}));

  // R7
  cc_nz_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !trap) |=> (cc_n == $past(result[MSB]) && cc_z == ($past(result) == '0)));

  // R10
  cc_v_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !trap) |=> !cc_v);

endmodule

bind tagged_arith_unit tagged_arith_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .op_valid (op_valid),
  .op_sub   (op_sub),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .trap     (trap),
  .cc_n     (cc_n),
  .cc_z     (cc_z),
  .cc_v     (cc_v),
  .cc_c     (cc_c)
);

// File: tb/tagged_arith_unit_test.sv
module tagged_arith_unit_test;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic        op_sub;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;
  logic        trap;
  logic        cc_n, cc_z, cc_v, cc_c;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic        valid;
    logic [31:0] res;
    logic        trap;
    logic [3:0]  cc;
    string       tag;
  } item_t;

  item_t      q[$];
  logic [3:0] model_cc;

  tagged_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .trap(trap),
    .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: presents one cycle and pushes the expected outcome
  task automatic drive(input logic v, input logic s, input logic [31:0] a, input logic [31:0] b, input string tag);
    item_t       it;
    logic [32:0] w;
    logic        ovf, tagbad, c;
    @(negedge clk);
    op_valid = v; op_sub = s; opnd_a = a; opnd_b = b;
    tagbad = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
    if (!s) begin
      w   = {1'b0, a} + {1'b0, b};
      c   = (w[31:0] < a);
      ovf = (a[31] == b[31]) && (w[31] != a[31]);
    end else begin
      w   = {1'b0, a} - {1'b0, b};
      c   = (a < b);
      ovf = (a[31] != b[31]) && (w[31] != a[31]);
    end
    it.valid = v;
    it.res   = w[31:0];
    it.trap  = v && (tagbad || ovf);
    if (v && !it.trap) model_cc = {w[31], (w[31:0] == 32'h0), 1'b0, c};
    it.cc  = model_cc;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(trap === it.trap, it.tag, {31'b0, trap}, {31'b0, it.trap});
        if (it.valid && !it.trap)
          check(result === it.res, it.tag, result, it.res);
        @(posedge clk);
        #1;
        check({cc_n, cc_z, cc_v, cc_c} === it.cc, it.tag,
              {28'b0, cc_n, cc_z, cc_v, cc_c}, {28'b0, it.cc});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
    model_cc = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    check({cc_n, cc_z, cc_v, cc_c} === 4'b0000, "R11 in reset", {28'b0, cc_n, cc_z, cc_v, cc_c}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check({cc_n, cc_z, cc_v, cc_c} === 4'b0000, "R11 after release", {28'b0, cc_n, cc_z, cc_v, cc_c}, 32'h0);

    drive(1, 0, 32'h0000_0100, 32'h0000_0200, "R4 R7 add plain");
    drive(1, 0, 32'hFFFF_FFFC, 32'h0000_0008, "R8 add carry");
    drive(1, 0, 32'h0000_0101, 32'h0000_0200, "R1 tag a bit0");
    drive(1, 1, 32'h0000_0100, 32'h0000_0002, "R1 tag b bit1 sub");
    drive(1, 0, 32'h7FFF_FFFC, 32'h0000_0004, "R2 add pos ovf");
    drive(1, 0, 32'h8000_0000, 32'h8000_0000, "R2 add neg ovf");
    drive(1, 0, 32'hFFFF_FFFC, 32'h0000_0004, "R7 R8 add to zero");
    drive(1, 0, 32'h8000_0000, 32'h7FFF_FFFC, "R4 R10 add mixed sign");
    drive(1, 1, 32'h8000_0000, 32'h0000_0004, "R3 sub neg ovf");
    drive(1, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, "R3 sub pos ovf");
    drive(1, 1, 32'h0000_0004, 32'h0000_0008, "R9 sub borrow");
    drive(0, 0, 32'h0000_0003, 32'h0000_0001, "R5 R6 idle bad tags");
    drive(1, 1, 32'h0000_0008, 32'h0000_0008, "R9 R7 sub equal");
    drive(0, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, "R5 R6 idle ovf operands");
    drive(1, 1, 32'h1234_5678, 32'h0000_0010, "R4 sub plain");
    drive(1, 1, 32'hFFFF_FFF0, 32'hFFFF_FFFC, "R9 sub big-big");
    drive(0, 0, 32'h0, 32'h0, "R6 idle");
    drive(0, 0, 32'h0, 32'h0, "R6 idle");
    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule